// File: doc/BRIEF.md
# Half-Screen Line Buffer Compositor

This block builds each output video line from the input line arriving in the same line period. The output pixel stream feeds a DVI/TMDS encoder. The left half of every active output line is forced to black. The right half shows pixels taken from a one-line dual-port RAM that is being filled from the input stream while the output scans. Only a single line of storage is needed, so no frame has to be fetched from external memory.

Each accepted source pixel is stored twice, in two neighbouring RAM entries, which doubles the source horizontally. A source line of `H_ACTIVE/4` pixels therefore fills the whole right half. The write side has two markers. A line-start marker restarts the fill at entry 0. A frame-start marker does the same and also clears a sticky underrun flag. The read side is driven by timing counters and a display-enable from an external sync generator. The RAM read takes one cycle, so the output select is delayed by one cycle to stay aligned with the read data. Rows outside a vertical window set by parameters, and all blanking time, produce black.

Top module: `halfscreen_compositor`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_rgb` is 0 and `underrun` is 0.
- R2: During an active, in-window row, any column below `H_ACTIVE/2` (640 by default) outputs 0, whatever is stored.
- R3: During an active, in-window row, column c with 640 ≤ c < 1280 gives RAM entry c−640 on `out_rgb` exactly one cycle after c is presented.
- R4: An accepted source pixel is written to two consecutive entries: first to entry n, then in the next cycle to entry n+1.
- R5: `in_valid` in the cycle right after an accepted pixel (the repeat cycle) is ignored. Nothing is written for it and the fill position does not move.
- R6: A pixel accepted with `in_line_start` or `in_frame_start` high is written to entries 0 and 1, even in the middle of a line. Entries beyond are left untouched.
- R7: When `out_active` is low, `out_rgb` is 0 in the following cycle.
- R8: Rows below `VWIN_FIRST` (40) or above `VWIN_LAST` (679) output 0 across the whole line. Both bounds are inside the window.
- R9: A right-half read of an entry not yet written in the current input line sets `underrun` in the next cycle. The flag then stays set. Reads of written entries never set it.
- R10: A pixel accepted with `in_frame_start` clears `underrun` in the next cycle.
- R11: Writes beyond entry 639 in a line are dropped. They never wrap onto entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source pixel present |
| in_line_start | input | 1 | With `in_valid`: first pixel of an input line |
| in_frame_start | input | 1 | With `in_valid`: first pixel of a frame; also restarts the line |
| in_pixel | input | PIX_W (24) | Source pixel, packed RGB |
| out_active | input | 1 | Display enable from the timing generator |
| out_hcount | input | TW (12) | Output column counter |
| out_vcount | input | TW (12) | Output row counter |
| out_rgb | output | PIX_W (24) | Pixel toward the encoder |
| underrun | output | 1 | Sticky: the read side overtook the write side |

## Verification
Each fault in the fill position shows up one cycle after the affected column is presented. A stuck or skipped pointer shifts or duplicates the right-half picture. A missed restart leaves the pair at entries 0 and 1 stale. A pointer that wraps overwrites the first pixel of the line. If the select pipeline is off by a cycle, the picture on the right half moves by one column. If the select ignores blanking or the window, stored data appears in the left half, in blanking, or on rows outside the window, on the very next cycle. A wrong fill count makes `underrun` rise either too early or never, again one cycle after the read in question.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

  // Column lies in the half of the line that carries stored pixels.
  function automatic logic in_right_half(input int unsigned col,
                                         input int unsigned half,
                                         input int unsigned width);
    return (col >= half) && (col < width);
  endfunction

  // RAM entry that a right-half column displays.
  function automatic int unsigned right_offset(input int unsigned col,
                                               input int unsigned half);
    return col - half;
  endfunction

  // Row falls inside the inclusive vertical window.
  function automatic logic row_in_window(input int unsigned row,
                                         input int unsigned first,
                                         input int unsigned last);
    return (row >= first) && (row <= last);
  endfunction

  // Entry index exists in a line of the given depth.
  function automatic logic slot_exists(input int unsigned idx,
                                       input int unsigned depth);
    return idx < depth;
  endfunction

  // Entry has already been filled in the current line.
  function automatic logic entry_filled(input int unsigned idx,
                                        input int unsigned filled);
    return idx < filled;
  endfunction

endpackage

// File: rtl/hsc_line_ram.sv
module hsc_line_ram #(
  parameter int unsigned DEPTH  = 640,
  parameter int unsigned WIDTH  = 24,
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_q
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Write port
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Read port: registered, returns the content before a same-cycle write
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end

endmodule

// File: rtl/hsc_line_writer.sv
module hsc_line_writer #(
  parameter int unsigned HALF   = 640,
  parameter int unsigned PIX_W  = 24,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_line_start,
  input  logic              in_frame_start,
  input  logic [PIX_W-1:0]  in_pixel,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PIX_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  wr_cnt,
  output logic              wr_accept,
  output logic              frame_clear
);

  logic              rep_pend;  // second copy of the last pixel is due
  logic [PIX_W-1:0]  rep_pix;
  logic [CNT_W-1:0]  fill_ptr;  // entries filled in the current line
  logic              restart;
  logic              busy;
  logic [CNT_W-1:0]  target;

  assign wr_accept   = in_valid && !rep_pend;
  assign restart     = wr_accept && (in_line_start || in_frame_start);
  assign frame_clear = wr_accept && in_frame_start;
  assign busy        = wr_accept || rep_pend;
  assign target      = restart ? '0 : fill_ptr;

  assign wr_en   = busy && hsc_pkg::slot_exists(32'(target), HALF);
  assign wr_addr = ADDR_W'(target);
  assign wr_data = wr_accept ? in_pixel : rep_pix;
  assign wr_cnt  = fill_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_pend <= 1'b0;
      rep_pix  <= '0;
      fill_ptr <= '0;
    end else begin
      rep_pend <= wr_accept;
      if (wr_accept) rep_pix <= in_pixel;
      if (wr_en) fill_ptr <= target + CNT_W'(1);
    end
  end

endmodule

// File: rtl/hsc_line_reader.sv
module hsc_line_reader #(
  parameter int unsigned H_ACTIVE   = 1280,
  parameter int unsigned HALF       = 640,
  parameter int unsigned PIX_W      = 24,
  parameter int unsigned TW         = 12,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned VWIN_FIRST = 40,
  parameter int unsigned VWIN_LAST  = 679
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_active,
  input  logic [TW-1:0]     out_hcount,
  input  logic [TW-1:0]     out_vcount,
  input  logic [CNT_W-1:0]  wr_cnt,
  input  logic              frame_clear,
  input  logic [PIX_W-1:0]  ram_q,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_miss,
  output logic [PIX_W-1:0]  out_rgb,
  output logic              underrun
);

  logic sel_now;
  logic sel_q;   // select aligned with the registered RAM output

  assign sel_now = out_active
                && hsc_pkg::row_in_window(32'(out_vcount), VWIN_FIRST, VWIN_LAST)
                && hsc_pkg::in_right_half(32'(out_hcount), HALF, H_ACTIVE);

  assign rd_en   = sel_now;
  assign rd_addr = ADDR_W'(hsc_pkg::right_offset(32'(out_hcount), HALF));
  assign rd_miss = sel_now && !hsc_pkg::entry_filled(32'(rd_addr), 32'(wr_cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      sel_q <= sel_now;
      if (frame_clear)  underrun <= 1'b0;
      else if (rd_miss) underrun <= 1'b1;
    end
  end

  assign out_rgb = sel_q ? ram_q : '0;

endmodule

// File: rtl/halfscreen_compositor.sv
module halfscreen_compositor #(
  parameter int unsigned H_ACTIVE   = 1280,
  parameter int unsigned PIX_W      = 24,
  parameter int unsigned TW         = 12,
  parameter int unsigned VWIN_FIRST = 40,
  parameter int unsigned VWIN_LAST  = 679
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_line_start,
  input  logic             in_frame_start,
  input  logic [PIX_W-1:0] in_pixel,
  input  logic             out_active,
  input  logic [TW-1:0]    out_hcount,
  input  logic [TW-1:0]    out_vcount,
  output logic [PIX_W-1:0] out_rgb,
  output logic             underrun
);

  localparam int unsigned HALF   = H_ACTIVE / 2;
  localparam int unsigned ADDR_W = $clog2(HALF);
  localparam int unsigned CNT_W  = $clog2(HALF + 1);

  // Named internal events, observed by the bound checker
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [PIX_W-1:0]  wr_data;
  logic [CNT_W-1:0]  wr_cnt;
  logic              wr_accept;
  logic              frame_clear;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_miss;
  logic [PIX_W-1:0]  ram_q;

  hsc_line_writer #(
    .HALF(HALF), .PIX_W(PIX_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_writer (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_line_start(in_line_start),
    .in_frame_start(in_frame_start), .in_pixel(in_pixel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_cnt(wr_cnt), .wr_accept(wr_accept), .frame_clear(frame_clear)
  );

  hsc_line_ram #(
    .DEPTH(HALF), .WIDTH(PIX_W), .ADDR_W(ADDR_W)
  ) u_ram (
    .clk(clk),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_q(ram_q)
  );

  hsc_line_reader #(
    .H_ACTIVE(H_ACTIVE), .HALF(HALF), .PIX_W(PIX_W), .TW(TW),
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .VWIN_FIRST(VWIN_FIRST), .VWIN_LAST(VWIN_LAST)
  ) u_reader (
    .clk(clk), .rst_n(rst_n),
    .out_active(out_active), .out_hcount(out_hcount), .out_vcount(out_vcount),
    .wr_cnt(wr_cnt), .frame_clear(frame_clear), .ram_q(ram_q),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_miss(rd_miss),
    .out_rgb(out_rgb), .underrun(underrun)
  );

endmodule

// File: rtl/hsc_checker.sv
module hsc_checker #(
  parameter int unsigned H_ACTIVE   = 1280,
  parameter int unsigned PIX_W      = 24,
  parameter int unsigned TW         = 12,
  parameter int unsigned VWIN_FIRST = 40,
  parameter int unsigned VWIN_LAST  = 679,
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned CNT_W      = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_line_start,
  input logic              in_frame_start,
  input logic              out_active,
  input logic [TW-1:0]     out_hcount,
  input logic [TW-1:0]     out_vcount,
  input logic [PIX_W-1:0]  out_rgb,
  input logic              underrun,
  input logic              wr_accept,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [PIX_W-1:0]  wr_data,
  input logic [CNT_W-1:0]  wr_cnt,
  input logic              rd_miss,
  input logic              frame_clear
);

  localparam int unsigned HALF = H_ACTIVE / 2;
  localparam logic [TW-1:0]     HALF_T  = TW'(HALF);
  localparam logic [TW-1:0]     FIRST_T = TW'(VWIN_FIRST);
  localparam logic [TW-1:0]     LAST_T  = TW'(VWIN_LAST);
  localparam logic [ADDR_W-1:0] LASTE_T = ADDR_W'(HALF - 1);
  localparam logic [CNT_W-1:0]  FULL_T  = CNT_W'(HALF);

  // R1
  a_r1_reset_black: assert property (@(posedge clk)
    !rst_n |=> (out_rgb == '0) && !underrun);

  // R2
  a_r2_left_black: assert property (@(posedge clk) disable iff (!rst_n)
    out_active && (out_hcount < HALF_T) |=> out_rgb == '0);

  // R7
  a_r7_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
    !out_active |=> out_rgb == '0);

  // R8
  a_r8_window_black: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vcount < FIRST_T) || (out_vcount > LAST_T) |=> out_rgb == '0);

  // R4: the second copy lands in the following entry with the same data
  a_r4_double_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept && wr_en && (wr_addr != LASTE_T)
      |=> wr_en && (wr_addr == $past(wr_addr) + ADDR_W'(1))
                && (wr_data == $past(wr_data)));

  // R5
  a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !wr_accept);

  // R6
  a_r6_restart_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept && (in_line_start || in_frame_start)
      |=> (wr_cnt == CNT_W'(1)));

  // R9
  a_r9_underrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    rd_miss && !frame_clear |=> underrun);

  a_r9_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !frame_clear |=> underrun);

  // R10
  a_r10_frame_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clear |=> !underrun);

  // R11
  a_r11_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt <= FULL_T);

endmodule

bind halfscreen_compositor hsc_checker #(
  .H_ACTIVE(H_ACTIVE), .PIX_W(PIX_W), .TW(TW),
  .VWIN_FIRST(VWIN_FIRST), .VWIN_LAST(VWIN_LAST),
  .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_hsc_checker (
  .clk(clk), .rst_n(rst_n),
  .in_line_start(in_line_start), .in_frame_start(in_frame_start),
  .out_active(out_active), .out_hcount(out_hcount), .out_vcount(out_vcount),
  .out_rgb(out_rgb), .underrun(underrun),
  .wr_accept(wr_accept), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .wr_cnt(wr_cnt), .rd_miss(rd_miss), .frame_clear(frame_clear)
);

// File: tb/tb_halfscreen_compositor.sv
module tb_halfscreen_compositor;

  localparam int W     = 1280;
  localparam int HALFW = 640;
  localparam int VF    = 40;
  localparam int VL    = 679;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_line_start = 1'b0;
  logic        in_frame_start = 1'b0;
  logic [23:0] in_pixel = '0;
  logic        out_active = 1'b0;
  logic [11:0] out_hcount = '0;
  logic [11:0] out_vcount = '0;
  logic [23:0] out_rgb;
  logic        underrun;

  halfscreen_compositor dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_line_start(in_line_start),
    .in_frame_start(in_frame_start), .in_pixel(in_pixel),
    .out_active(out_active), .out_hcount(out_hcount), .out_vcount(out_vcount),
    .out_rgb(out_rgb), .underrun(underrun)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  logic [23:0] model [HALFW];
  int m_ptr = 0;

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] pix_of(input int seed, input int k);
    logic [23:0] p;
    int t;
    t = k * 3 + seed;
    p[23:17] = seed[6:0];
    p[16:8]  = k[8:0];
    p[7:0]   = t[7:0];
    return p;
  endfunction

  task automatic m_put(input logic [23:0] p);
    if (m_ptr < HALFW) begin
      model[m_ptr] = p;
      m_ptr++;
    end
  endtask

  // Expected output for a column, from R2, R3, R7, R8
  function automatic logic [23:0] exp_pix(input int row, input int col, input logic act);
    if (!act || row < VF || row > VL || col < HALFW || col >= W) return '0;
    return model[col - HALFW];
  endfunction

  // One accepted pixel followed by its repeat cycle (R4)
  task automatic push_px(input logic [23:0] p, input logic ls, input logic fs);
    in_pixel = p; in_line_start = ls; in_frame_start = fs; in_valid = 1'b1;
    if (ls || fs) m_ptr = 0;
    m_put(p);
    m_put(p);
    @(negedge clk);
    in_valid = 1'b0; in_line_start = 1'b0; in_frame_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic push_line(input int seed, input int n);
    for (int k = 0; k < n; k++) push_px(pix_of(seed, k), k == 0, 1'b0);
  endtask

  task automatic read_cols(input string req, input int row, input int c0, input int c1,
                           input logic act);
    for (int c = c0; c <= c1; c++) begin
      out_hcount = 12'(c); out_vcount = 12'(row); out_active = act;
      @(negedge clk);
      chk(req, out_rgb, exp_pix(row, c, act));
    end
    out_active = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 rgb in reset", out_rgb, '0);
    chk("R1 underrun in reset", {23'd0, underrun}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rgb after reset", out_rgb, '0);
    chk("R1 underrun after reset", {23'd0, underrun}, '0);
  endtask

  task automatic t_full_line();
    push_line(5, HALFW / 2);
    read_cols("R2/R3/R4 full line", 100, 0, W - 1, 1'b1);
    chk("R9 no false underrun", {23'd0, underrun}, '0);
  endtask

  task automatic t_blanking();
    read_cols("R7 blanking", 100, 0, W - 1, 1'b0);
  endtask

  task automatic t_window();
    read_cols("R8 row above window", VF - 1, HALFW - 2, W - 1, 1'b1);
    read_cols("R8 first row", VF, HALFW - 2, W - 1, 1'b1);
    read_cols("R8 last row", VL, HALFW - 2, W - 1, 1'b1);
    read_cols("R8 row below window", VL + 1, HALFW - 2, W - 1, 1'b1);
  endtask

  // Fill and drain in the same line
  task automatic t_concurrent();
    fork
      push_line(9, HALFW / 2);
      read_cols("R3 concurrent fill/drain", 200, 0, W - 1, 1'b1);
    join
    chk("R9 write leads read", {23'd0, underrun}, '0);
  endtask

  task automatic t_overflow();
    push_line(17, HALFW / 2 + 1);
    read_cols("R11 overflow dropped", 300, HALFW, HALFW + 1, 1'b1);
    read_cols("R11 tail", 300, W - 2, W - 1, 1'b1);
  endtask

  task automatic t_repeat_ignore();
    logic [23:0] pa;
    logic [23:0] pb;
    pa = 24'h11_22_33; pb = 24'hAA_BB_CC;
    in_pixel = pa; in_line_start = 1'b1; in_valid = 1'b1;
    m_ptr = 0; m_put(pa); m_put(pa);
    @(negedge clk);
    in_pixel = pb; in_line_start = 1'b0; in_valid = 1'b1;   // repeat cycle: ignored
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    push_px(24'h44_55_66, 1'b0, 1'b0);
    read_cols("R5 repeat-cycle valid ignored", 300, HALFW, HALFW + 3, 1'b1);
  endtask

  task automatic t_restart();
    push_line(21, HALFW / 2);
    push_px(24'h0D_0D_0D, 1'b1, 1'b0);
    read_cols("R6 line start restarts", 300, HALFW, HALFW + 2, 1'b1);
    push_px(24'h0E_0E_0E, 1'b0, 1'b1);
    read_cols("R6 frame start restarts", 300, HALFW, HALFW + 1, 1'b1);
  endtask

  task automatic t_underrun();
    push_px(24'h01_01_01, 1'b0, 1'b1);
    chk("R10 frame start clears", {23'd0, underrun}, '0);
    push_px(24'h0A_0A_0A, 1'b1, 1'b0);
    push_px(24'h0B_0B_0B, 1'b0, 1'b0);
    read_cols("R9 filled entries", 300, HALFW, HALFW + 3, 1'b1);
    chk("R9 no underrun on filled", {23'd0, underrun}, '0);
    out_hcount = 12'(HALFW + 4); out_vcount = 12'd300; out_active = 1'b1;
    @(negedge clk);
    out_active = 1'b0;
    chk("R9 underrun set next cycle", {23'd0, underrun}, 24'd1);
    repeat (5) @(negedge clk);
    chk("R9 underrun sticky", {23'd0, underrun}, 24'd1);
    in_pixel = 24'h02_02_02; in_frame_start = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_frame_start = 1'b0;
    chk("R10 clear next cycle", {23'd0, underrun}, '0);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_full_line();
    t_blanking();
    t_window();
    t_concurrent();
    t_overflow();
    t_repeat_ignore();
    t_restart();
    t_underrun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule